// File: doc/BRIEF.md
# CDR Lock-Loss Watchdog

This block supervises a serial receiver's clock-and-data-recovery loop. The loop reports two status levels: a phase-lock flag and a frequency-lock flag. If both stay low past a programmed limit, the loop is assumed to be stuck. This can happen after the line input was floating or a cable was plugged in while the link was powered. To re-initialise the receiver, the watchdog then drives the receiver's analog reset (power-down) high for a fixed number of cycles.

The watchdog runs from a free-running clock that does not depend on the receiver. Both status flags are brought into that clock domain through two-flop synchronizers. A small state machine moves through three phases: monitoring, reset pulse, and holdoff. During holdoff the receiver has time to reacquire before loss timing starts again. All three lengths are parameters given in clock cycles. The defaults suit a 100 MHz clock: a loss limit of just over 50 µs, a 1 µs pulse and a 200 µs holdoff.

Top module: `cdr_lock_watchdog`

## Requirements
- R1: Each status input passes through a two-flop synchronizer before the loss timer sees it. When both pins drop low just before a rising edge E0, rx_analogreset is high after edge E0+TIMEOUT_CYC+2 and not before.
- R2: rx_analogreset is high from the first clock edge with rst_n low, including a reset applied in mid-operation. After rst_n is released, it falls on the PULSE_CYC-th rising edge, and a holdoff of HOLDOFF_CYC cycles follows.
- R3: While at least one of rx_locked or rx_freqlocked is high, no analog reset pulse is issued, whichever of the two is the high one.
- R4: A pulse is issued only after both synchronized flags have been low for TIMEOUT_CYC+1 consecutive cycles. A loss of TIMEOUT_CYC cycles or fewer causes no pulse.
- R5: A high level on either status input for a single cycle clears the loss timer to zero, so the full timeout restarts once both flags are low again.
- R6: Each lock-loss pulse on rx_analogreset is high for exactly PULSE_CYC cycles.
- R7: After each pulse a holdoff of HOLDOFF_CYC cycles follows, during which the loss timer stays at zero. If the loss persists, the next pulse starts PULSE_CYC+HOLDOFF_CYC+TIMEOUT_CYC+1 cycles after the previous one started. If lock returns, the block goes back to monitoring with no further pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_locked | input | 1 | Receiver phase-lock status, asynchronous |
| rx_freqlocked | input | 1 | Receiver frequency-lock status, asynchronous |
| rx_analogreset | output | 1 | Analog reset / power-down to the receiver, active high |

## Verification
A fault in the loss counter shows at the port as a pulse that starts one or more cycles away from the exact TIMEOUT_CYC+3 edge latency. It can also show as a pulse after a loss that was one cycle too short. A fault in the phase counter of the state machine changes the pulse width or the spacing between repeated pulses, and it is visible on the first pulse. A stuck synchronizer or a broken timer clear shows at the ports within one timeout window, as an early, late or missing pulse.

// File: rtl/lockwd_pkg.sv
// Shared types for the CDR lock-loss watchdog.
package lockwd_pkg;
    // Watchdog phases: timing loss, driving reset, waiting for reacquisition.
    typedef enum logic [1:0] {
        ST_MONITOR = 2'd0,
        ST_PULSE   = 2'd1,
        ST_HOLDOFF = 2'd2
    } wd_state_t;
endpackage

// File: rtl/lockwd_sync.sv
// Multi-stage level synchronizer for one asynchronous status bit.
// Assumes the input is a slow level; resets to 0 (treated as "not locked").
module lockwd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lockwd_timer.sv
// Loss timer: counts consecutive cycles of lock loss while enabled.
// It raises expire when loss has lasted TIMEOUT_CYC+1 cycles.
// It is held at zero whenever it is disabled or lock is present.
module lockwd_timer #(
    parameter int TIMEOUT_CYC = 5000,
    parameter int CW          = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          lost,
    output logic          expire,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

    // Advance on sustained loss, saturate at the limit, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !lost) count <= '0;
        else if (count != LIMIT)        count <= count + 1'b1;
    end

    assign expire = enable && lost && (count == LIMIT);
endmodule

// File: rtl/lockwd_fsm.sv
// Sequencer: monitor -> reset pulse -> holdoff -> monitor.
// Reset places it in the pulse phase, so the receiver is held in reset
// while rst_n is low and gets one full pulse after release.
module lockwd_fsm
    import lockwd_pkg::*;
#(
    parameter int PULSE_CYC   = 100,
    parameter int HOLDOFF_CYC = 20000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      expire,
    output wd_state_t state,
    output logic      areset
);
    localparam int PH_MAX = (PULSE_CYC > HOLDOFF_CYC) ? PULSE_CYC : HOLDOFF_CYC;
    localparam int PW     = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;
    localparam logic [PW-1:0] PULSE_END = PW'(PULSE_CYC - 1);
    localparam logic [PW-1:0] HOLD_END  = PW'(HOLDOFF_CYC - 1);

    logic [PW-1:0] phase;

    // Phase transitions and the in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_PULSE;
            phase <= '0;
        end else begin
            unique case (state)
                ST_MONITOR: begin
                    phase <= '0;
                    if (expire) state <= ST_PULSE;
                end
                ST_PULSE: begin
                    if (phase == PULSE_END) begin
                        state <= ST_HOLDOFF;
                        phase <= '0;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_HOLDOFF: begin
                    if (phase == HOLD_END) begin
                        state <= ST_MONITOR;
                        phase <= '0;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                default: begin
                    state <= ST_PULSE;
                    phase <= '0;
                end
            endcase
        end
    end

    // Reset output follows the pulse phase.
    assign areset = (state == ST_PULSE);
endmodule

// File: rtl/cdr_lock_watchdog.sv
// CDR lock-loss watchdog top.
// Synchronizes both lock flags and times their joint absence.
// When the limit is exceeded it issues a timed analog reset, then a holdoff.
// Assumes clk is free-running and does not depend on the receiver.
module cdr_lock_watchdog
    import lockwd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000,
    parameter int PULSE_CYC   = 100,
    parameter int HOLDOFF_CYC = 20000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_locked,
    input  logic rx_freqlocked,
    output logic rx_analogreset
);
    localparam int NSTAT = 2;
    localparam int CW    = $clog2(TIMEOUT_CYC + 1);

    logic [NSTAT-1:0] raw_stat;
    logic [NSTAT-1:0] sync_stat;
    logic             sync_lost;
    logic             expire;
    logic [CW-1:0]    loss_cnt;
    wd_state_t        fsm_state;

    assign raw_stat = {rx_freqlocked, rx_locked};

    // One synchronizer per status flag.
    for (genvar i = 0; i < NSTAT; i++) begin : g_sync
        lockwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (raw_stat[i]),
            .q    (sync_stat[i])
        );
    end

    // Loss means neither flag is present.
    assign sync_lost = ~|sync_stat;

    lockwd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(fsm_state == ST_MONITOR),
        .lost  (sync_lost),
        .expire(expire),
        .count (loss_cnt)
    );

    lockwd_fsm #(.PULSE_CYC(PULSE_CYC), .HOLDOFF_CYC(HOLDOFF_CYC)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .expire(expire),
        .state (fsm_state),
        .areset(rx_analogreset)
    );
endmodule

// File: rtl/cdr_lock_watchdog_chk.sv
// Assertion checker for cdr_lock_watchdog, attached by bind.
module cdr_lock_watchdog_chk
    import lockwd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5000,
    parameter int CW          = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_locked,
    input logic          rx_freqlocked,
    input logic          rx_analogreset,
    input logic          sync_lost,
    input logic          expire,
    input logic [CW-1:0] loss_cnt,
    input wd_state_t     fsm_state
);
    logic [1:0] age;

    // Edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)        age <= '0;
        else if (age != 3) age <= age + 1'b1;
    end

    // R1: internal loss view lags the pins by two edges.
    a_r1_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2) |-> (sync_lost == $past(!rx_locked && !rx_freqlocked, 2)));

    // R3: no expiry while any lock flag is present.
    a_r3_no_expire_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_lost |-> !expire);

    // R4: expiry starts the pulse on the next cycle.
    a_r4_expire_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (fsm_state == ST_PULSE && rx_analogreset));

    // R5: lock seen clears the timer.
    a_r5_clear_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_lost |=> (loss_cnt == '0));

    // R4: timer never passes its limit.
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        loss_cnt <= CW'(TIMEOUT_CYC));

    // R7: holdoff keeps the timer cleared and the reset low.
    a_r7_holdoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_HOLDOFF) |-> (loss_cnt == '0 && !rx_analogreset));

    // R7: end of a pulse always enters holdoff.
    a_r7_fall_to_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_analogreset) |-> (fsm_state == ST_HOLDOFF));
endmodule

bind cdr_lock_watchdog cdr_lock_watchdog_chk #(
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .CW         (CW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_locked     (rx_locked),
    .rx_freqlocked (rx_freqlocked),
    .rx_analogreset(rx_analogreset),
    .sync_lost     (sync_lost),
    .expire        (expire),
    .loss_cnt      (loss_cnt),
    .fsm_state     (fsm_state)
);

// File: tb/cdr_lock_watchdog_test.sv
`timescale 1ns/1ps
module cdr_lock_watchdog_test;
    localparam int T = 8;
    localparam int P = 3;
    localparam int H = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_locked = 1'b1;
    logic rx_freqlocked = 1'b1;
    logic rx_analogreset;
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;

    always #2.5 clk = ~clk;

    cdr_lock_watchdog #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .HOLDOFF_CYC(H)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_locked     (rx_locked),
        .rx_freqlocked (rx_freqlocked),
        .rx_analogreset(rx_analogreset)
    );

    // Watchdog on the run length.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected<=50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Samples (one per cycle) until the output equals val; -1 if never.
    task automatic until_out(input logic val, input int limit, output int n);
        n = -1;
        for (int k = 1; k <= limit; k++) begin
            tick(1);
            if (rx_analogreset == val) begin
                n = k;
                break;
            end
        end
    endtask

    // Counts the cycles the output is high over a window.
    task automatic count_high(input int win, output int hi);
        hi = 0;
        for (int k = 0; k < win; k++) begin
            tick(1);
            if (rx_analogreset) hi = hi + 1;
        end
    endtask

    initial begin
        int n;
        int hi;
        tick(3);
        chk(rx_analogreset == 1'b1, "R2 high during reset", rx_analogreset, 1);
        rst_n = 1'b1;
        until_out(1'b0, 50, n);
        chk(n == P, "R2 release pulse length", n, P);
        count_high(H + 60, hi);
        chk(hi == 0, "R3 both locked quiet", hi, 0);

        rx_locked = 1'b0; rx_freqlocked = 1'b1;
        count_high(60, hi);
        chk(hi == 0, "R3 freqlocked alone holds off", hi, 0);
        rx_locked = 1'b1; rx_freqlocked = 1'b0;
        count_high(60, hi);
        chk(hi == 0, "R3 locked alone holds off", hi, 0);

        // Sustained loss: latency, width, repeat spacing.
        rx_locked = 1'b0; rx_freqlocked = 1'b0;
        until_out(1'b1, 100, n);
        chk(n == T + 3, "R1 R4 loss to reset latency", n, T + 3);
        until_out(1'b0, 100, n);
        chk(n == P, "R6 pulse width", n, P);
        until_out(1'b1, 100, n);
        chk(n == H + T + 1, "R7 repeat spacing after holdoff", n, H + T + 1);
        rx_locked = 1'b1;
        until_out(1'b0, 100, n);
        chk(n == P, "R6 second pulse width", n, P);
        count_high(H + 60, hi);
        chk(hi == 0, "R7 recovery returns to monitor", hi, 0);

        // Sweep loss durations across the threshold.
        for (int len = 1; len <= T + 3; len++) begin
            rx_locked = 1'b0; rx_freqlocked = 1'b0;
            hi = 0;
            for (int k = 1; k <= T + P + H + 12; k++) begin
                tick(1);
                if (k == len) begin
                    rx_locked = 1'b1; rx_freqlocked = 1'b1;
                end
                if (rx_analogreset) hi = hi + 1;
            end
            chk(hi == ((len >= T + 1) ? P : 0), "R4 loss length sweep", hi,
                (len >= T + 1) ? P : 0);
        end

        // One-cycle glitch on either flag restarts the timeout.
        for (int which = 0; which < 2; which++) begin
            rx_locked = 1'b0; rx_freqlocked = 1'b0;
            tick(T);
            if (which == 0) rx_freqlocked = 1'b1; else rx_locked = 1'b1;
            tick(1);
            rx_locked = 1'b0; rx_freqlocked = 1'b0;
            until_out(1'b1, 100, n);
            chk(n == T + 3, "R5 glitch restarts timer", n, T + 3);
            rx_locked = 1'b1; rx_freqlocked = 1'b1;
            until_out(1'b0, 100, n);
            count_high(H + 20, hi);
        end

        // Reset applied mid-operation.
        rst_n = 1'b0;
        tick(1);
        chk(rx_analogreset == 1'b1, "R2 mid-run reset asserts output", rx_analogreset, 1);
        rst_n = 1'b1;
        until_out(1'b0, 50, n);
        chk(n == P, "R2 mid-run release pulse length", n, P);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule